// File: doc/BRIEF.md
# Serial Programming-Mode Unlock Detector

This block sits on the device side of a two-wire serial programming port. It listens to a data pin and a programming clock pin, both asynchronous to the system clock, while an active-low enable pin is held low. Each falling edge of the programming clock shifts one data bit into a 32-bit register, least-significant bit first. Once exactly 32 bits have arrived, the register is compared with a fixed unlock key. A configuration enable bit gates the comparison.

On a match, the block raises a programming-mode flag. It then sends the rest of the chip into programming: it holds the other logic in reset, pulses a clear to the address counter, and forces the I/Os to high-impedance inputs. The flag is sticky against any later clock or data activity. It drops only when the enable pin is released high. Releasing the pin also discards any key that was only partly shifted in.

Top module: `prog_entry_detector`

## Requirements
- R1: With `en_n_pin` low and `cfg_lv_en` = 1, shifting in the 32-bit key 0x4D434850 sets `prog_mode`. The key is sent least-significant bit first, so bit 0 is the first bit shifted in.
- R2: A 32-bit word that differs from the key in any single bit leaves `prog_mode` at 0.
- R3: When `cfg_lv_en` = 0 in the cycle the 32nd bit is evaluated, the correct key is ignored and `prog_mode` stays 0.
- R4: Key bits are collected only while `en_n_pin` is low. Releasing the pin clears the bit count and the shifted word, so bits sent before the release cannot complete a key afterwards.
- R5: Once set, `prog_mode` stays 1 through any further programming-clock or data activity while `en_n_pin` stays low. It returns to 0 on the third system-clock edge after `en_n_pin` goes high.
- R6: `io_hiz` and `core_rst` are 1 in exactly the cycles in which `prog_mode` is 1.
- R7: `addr_clr` is a single-cycle pulse. It is high in the first cycle in which `prog_mode` is 1.
- R8: Only the first 32 falling edges after `en_n_pin` goes low are used for matching. Any edges after that are ignored, so a leading extra bit followed by the key does not unlock.
- R9: Data is sampled on falling edges of `pclk_pin`. `prog_mode` rises on the fourth system-clock edge after the falling edge of `pclk_pin` that carries the 32nd bit. This delay comes from two synchronizer stages, edge detection and registered evaluation.
- R10: While `rst` is high, and in the first cycle after it is released, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n_pin | input | 1 | Active-low programming enable pin, asynchronous |
| pclk_pin | input | 1 | Programming clock pin, asynchronous |
| pdat_pin | input | 1 | Programming data pin, changes on the rising edge of pclk_pin |
| cfg_lv_en | input | 1 | Configuration bit that permits key-based entry |
| prog_mode | output | 1 | Programming mode is active |
| core_rst | output | 1 | Reset held on the remaining device logic while in programming mode |
| addr_clr | output | 1 | One-cycle clear for the address counter on entry |
| io_hiz | output | 1 | Forces all I/Os to high-impedance inputs |

## Verification
Two functions can land on the same system cycle: completing the 32nd key bit, and exiting because the enable pin was released. The bench provokes this by raising `en_n_pin` on the same system edge on which `pclk_pin` falls for the 32nd bit of a correct key. Because the enable path has one register fewer than the clock path, the exit wins, and the reference model expects no entry at all. A behavioural model built from queues of pin history predicts all four outputs on every clock. It is also run through a sticky-mode burst, a leading extra bit, a single flipped bit, a key presented with the configuration bit at 0, and a partial key split across a release.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;
  parameter int          KEY_LEN  = 32;
  parameter logic [31:0] KEY_VAL  = 32'h4D43_4850;
  localparam int         CNT_W    = $clog2(KEY_LEN + 1);

  // pin indices inside the synchronized pin bundle
  localparam int PIN_EN  = 0;
  localparam int PIN_CK  = 1;
  localparam int PIN_DT  = 2;
  localparam int NUM_PIN = 3;
endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pe_fall_detect.sv
module pe_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign fall = prev_q & ~level;
endmodule

// File: rtl/pe_key_shift.sv
module pe_key_shift
  import prog_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               fall,
  input  logic               dbit,
  output logic [KEY_LEN-1:0] word,
  output logic               done
);
  logic [CNT_W-1:0] cnt_q;
  logic             room;

  assign room = (cnt_q < CNT_W'(KEY_LEN));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
      word  <= '0;
      done  <= 1'b0;
    end else begin
      done <= fall && (cnt_q == CNT_W'(KEY_LEN - 1));
      if (fall && room) begin
        word  <= {dbit, word[KEY_LEN-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(KEY_LEN));

  assert_clear_on_release_R4: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt_q == '0) && !done);

  assert_done_full_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt_q == CNT_W'(KEY_LEN)));
endmodule

// File: rtl/pe_mode_ctrl.sv
module pe_mode_ctrl
  import prog_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               done,
  input  logic [KEY_LEN-1:0] word,
  input  logic               cfg_lv_en,
  output logic               prog_mode,
  output logic               core_rst,
  output logic               addr_clr,
  output logic               io_hiz
);
  logic hit;
  logic enter;

  assign hit   = done && (word == KEY_VAL[KEY_LEN-1:0]) && cfg_lv_en;
  assign enter = active && !prog_mode && hit;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      prog_mode <= 1'b0;
      core_rst  <= 1'b0;
      io_hiz    <= 1'b0;
      addr_clr  <= 1'b0;
    end else begin
      addr_clr <= enter;
      if (enter) begin
        prog_mode <= 1'b1;
        core_rst  <= 1'b1;
        io_hiz    <= 1'b1;
      end
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (active && prog_mode) |=> prog_mode);

  assert_exit_R5: assert property (@(posedge clk) disable iff (rst)
    !active |=> !prog_mode);

  assert_cfg_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_mode) |-> $past(cfg_lv_en));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    addr_clr |=> !addr_clr);

  assert_pulse_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_mode) |-> addr_clr);
endmodule

// File: rtl/prog_entry_detector.sv
module prog_entry_detector
  import prog_entry_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_n_pin,
  input  logic pclk_pin,
  input  logic pdat_pin,
  input  logic cfg_lv_en,
  output logic prog_mode,
  output logic core_rst,
  output logic addr_clr,
  output logic io_hiz
);
  localparam logic [NUM_PIN-1:0] PIN_RST = NUM_PIN'(1) << PIN_EN;

  logic [NUM_PIN-1:0] pins_raw;
  logic [NUM_PIN-1:0] pins_s;
  logic               active;
  logic               fall;
  logic [KEY_LEN-1:0] word;
  logic               done;

  always_comb begin
    pins_raw         = '0;
    pins_raw[PIN_EN] = en_n_pin;
    pins_raw[PIN_CK] = pclk_pin;
    pins_raw[PIN_DT] = pdat_pin;
  end

  pe_sync #(.W(NUM_PIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins_raw),
    .dout(pins_s)
  );

  assign active = ~pins_s[PIN_EN];

  pe_fall_detect u_fall (
    .clk  (clk),
    .rst  (rst),
    .level(pins_s[PIN_CK]),
    .fall (fall)
  );

  pe_key_shift u_shift (
    .clk   (clk),
    .rst   (rst),
    .active(active),
    .fall  (fall),
    .dbit  (pins_s[PIN_DT]),
    .word  (word),
    .done  (done)
  );

  pe_mode_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .done     (done),
    .word     (word),
    .cfg_lv_en(cfg_lv_en),
    .prog_mode(prog_mode),
    .core_rst (core_rst),
    .addr_clr (addr_clr),
    .io_hiz   (io_hiz)
  );

  assert_side_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    (io_hiz == prog_mode) && (core_rst == prog_mode));

  assert_no_mode_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (en_n_pin && $past(en_n_pin) && $past(en_n_pin, 2)) |=> !prog_mode);
endmodule

// File: tb/tb_prog_entry_detector.sv
module tb_prog_entry_detector;
  localparam logic [31:0] KEY  = 32'h4D43_4850;
  localparam int          HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n_pin = 1'b1, pclk_pin = 1'b0, pdat_pin = 1'b0, cfg_lv_en = 1'b1;
  logic prog_mode, core_rst, addr_clr, io_hiz;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prog_entry_detector dut (
    .clk(clk), .rst(rst), .en_n_pin(en_n_pin), .pclk_pin(pclk_pin),
    .pdat_pin(pdat_pin), .cfg_lv_en(cfg_lv_en), .prog_mode(prog_mode),
    .core_rst(core_rst), .addr_clr(addr_clr), .io_hiz(io_hiz)
  );

  // behavioural reference: pin history queues (index 0 = newest sample)
  bit en_h[$], ck_h[$], dt_h[$];
  int          m_cnt;
  bit [31:0]   m_word;
  bit          m_done, m_mode, m_aclr;

  task automatic model_clear();
    en_h = '{1'b1, 1'b1, 1'b1};
    ck_h = '{1'b0, 1'b0, 1'b0};
    dt_h = '{1'b0, 1'b0, 1'b0};
    m_cnt = 0; m_word = '0; m_done = 0; m_mode = 0; m_aclr = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (rst) begin
      model_clear();
    end else begin
      bit act, fl, db, nmode, naclr, ndone;
      act = !en_h[1];
      fl  = ck_h[2] && !ck_h[1];
      db  = dt_h[1];
      nmode = m_mode; naclr = 0;
      if (!act) nmode = 0;
      else if (!m_mode && m_done && m_word == KEY && cfg_lv_en) begin
        nmode = 1; naclr = 1;
      end
      if (!act) begin
        m_cnt = 0; m_word = '0; ndone = 0;
      end else begin
        ndone = fl && (m_cnt == 31);
        if (fl && m_cnt < 32) begin
          m_word = {db, m_word[31:1]};
          m_cnt++;
        end
      end
      m_done = ndone; m_mode = nmode; m_aclr = naclr;
      en_h.push_front(en_n_pin); void'(en_h.pop_back());
      ck_h.push_front(pclk_pin); void'(ck_h.pop_back());
      dt_h.push_front(pdat_pin); void'(dt_h.pop_back());
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R9 prog_mode timing", prog_mode, m_mode);
      chk("R6 io_hiz", io_hiz, m_mode);
      chk("R6 core_rst", core_rst, m_mode);
      chk("R7 addr_clr", addr_clr, m_aclr);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    pclk_pin = 1'b1; pdat_pin = b;
    idle(HALF);
    pclk_pin = 1'b0;
    idle(HALF - 1);
  endtask

  task automatic send_bits(input logic [63:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask

  task automatic release_pin();
    @(negedge clk); en_n_pin = 1'b1;
    idle(6);
  endtask

  task automatic engage();
    @(negedge clk); en_n_pin = 1'b0;
    idle(4);
  endtask

  initial begin
    idle(3);
    chk("R10 reset prog_mode", prog_mode, 1'b0);
    chk("R10 reset addr_clr", addr_clr, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset io_hiz", io_hiz, 1'b0);
    idle(2);

    // R1: correct key unlocks
    engage();
    send_bits({32'h0, KEY}, 32);
    idle(6);
    chk("R1 key unlock", prog_mode, 1'b1);

    // R5: sticky against more traffic
    send_bits(64'h0123_4567_89AB_CDEF, 40);
    chk("R5 sticky mode", prog_mode, 1'b1);
    @(negedge clk); en_n_pin = 1'b1;
    idle(2);
    chk("R5 still held two edges after release", prog_mode, 1'b1);
    @(negedge clk);
    chk("R5 exit third edge after release", prog_mode, 1'b0);
    idle(4);

    // R2: single flipped bit
    engage();
    send_bits({32'h0, KEY ^ 32'h0001_0000}, 32);
    idle(6);
    chk("R2 mismatch no entry", prog_mode, 1'b0);
    release_pin();

    // R3: configuration bit low
    cfg_lv_en = 1'b0;
    engage();
    send_bits({32'h0, KEY}, 32);
    idle(6);
    chk("R3 cfg off ignores key", prog_mode, 1'b0);
    release_pin();
    cfg_lv_en = 1'b1;

    // R4: partial key discarded across release
    engage();
    send_bits({48'h0, KEY[15:0]}, 16);
    release_pin();
    engage();
    send_bits({48'h0, KEY[31:16]}, 16);
    send_bits(64'h0, 16);
    idle(6);
    chk("R4 partial key discarded", prog_mode, 1'b0);
    release_pin();
    engage();
    send_bits({32'h0, KEY}, 32);
    idle(6);
    chk("R4 fresh key after release", prog_mode, 1'b1);
    release_pin();

    // R8: leading extra bit then key
    engage();
    send_bits({31'h0, KEY, 1'b1}, 33);
    idle(6);
    chk("R8 extra edge no entry", prog_mode, 1'b0);
    release_pin();

    // collision: release on the same edge as the 32nd falling clock edge
    engage();
    send_bits({32'h0, KEY}, 31);
    @(negedge clk);
    pclk_pin = 1'b1; pdat_pin = KEY[31];
    idle(HALF);
    pclk_pin = 1'b0; en_n_pin = 1'b1;
    idle(8);
    chk("R5 release beats completion", prog_mode, 1'b0);
    idle(4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule